// File: doc/BRIEF.md
# Terminal Layer-1 Activation Controller

This block is the terminal-side controller that brings a basic-rate four-wire subscriber line up and down. A line decoder supplies it with per-cycle indications: quiet line (INFO 0), some signal present, INFO 2, INFO 4 and loss of frame sync. It also takes a 4-bit command from the control channel, slip events from a phase comparator and a timebase tick. From these it picks the line signal the transmitter must send, reports its state as a 4-bit indication code with a one-cycle valid strobe, and pulses a strobe that tells the elastic buffer to resynchronise.

There are eight states: power down, power up, pending deactivation, pending activation, unsynchronized, synchronized, activated and slip. The two half-millisecond waits, from first INFO 4 to activated and out of slip, are counted in `HALF_MS_TICKS` pulses of `tick_i`. Line coding, framing, clocking and the T3 supervision timer sit outside this block. T3 stays with software, which ends a hung activation with a deactivate command.

Top module: `l1t_act_ctrl`

## Requirements
- R1: While `rst_ni` is low the block is in power down. It drives `tx_o` = 00 (INFO 0), `ind_o` = 1111, and `ind_vld_o` and `resync_o` low.
- R2: In power down with no line signal, command 0000 enters power up, which keeps sending INFO 0. The power-up indication 0111 is issued only once `clk_rdy_i` is high.
- R3: INFO 0 received in unsynchronized, synchronized, activated or slip enters pending deactivation (indication 0000). This takes priority over every other input.
- R4: In pending deactivation only a line signal (`rx_any_i`, to unsynchronized) or command 1111 (to power down) has any effect. Activation command 1000 and command 0000 are ignored.
- R5: Command 1000 in power down or power up enters pending activation. This state sends INFO 1 (`tx_o` = 01), reports 0111 and never leaves on its own: only a line signal or command 1111 ends it. In the power-down group of states, a line signal takes priority over any command.
- R6: A line signal in power down, power up, pending activation or pending deactivation enters unsynchronized. That state sends INFO 0 and reports 0100, and leaves on INFO 2 or INFO 4 to synchronized. Loss of sync in synchronized, activated or slip returns to unsynchronized.
- R7: Synchronized sends INFO 3 (`tx_o` = 11) and reports 1000.
- R8: Synchronized moves to activated (INFO 3, indication 1100) on the `HALF_MS_TICKS`-th tick counted from the first cycle in synchronized that sees INFO 4. It never moves there earlier.
- R9: In activated, a slip event enters slip (indication 0010, INFO 3). The event is `slip50_i` when `cfg_slip25_i` = 0 and `slip25_i` when it is 1; the other slip input is ignored. `resync_o` is high for exactly the first cycle of slip. Slip returns to activated after `HALF_MS_TICKS` ticks.
- R10: The tick count restarts on every state entry, so each visit to synchronized or slip waits the full interval.
- R11: `ind_o` changes only together with a one-cycle `ind_vld_o`. It carries the new state's code one cycle after the state change.
- R12: Command codes other than 0000, 1000 and 1111 have no effect in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_info0_i | input | 1 | INFO 0 (quiet line) received |
| rx_any_i | input | 1 | Any signal from network present |
| rx_info2_i | input | 1 | INFO 2 identified |
| rx_info4_i | input | 1 | INFO 4 identified |
| rx_lsync_i | input | 1 | Frame synchronism lost |
| cmd_i | input | 4 | Control-channel command code |
| clk_rdy_i | input | 1 | Local clocks running |
| slip50_i | input | 1 | Phase wander beyond wide threshold |
| slip25_i | input | 1 | Phase wander beyond narrow threshold |
| cfg_slip25_i | input | 1 | Select narrow slip threshold |
| tick_i | input | 1 | Timebase tick |
| tx_o | output | 2 | Line signal to send: 00 INFO 0, 01 INFO 1, 11 INFO 3 |
| ind_o | output | 4 | Indication code |
| ind_vld_o | output | 1 | New indication strobe |
| resync_o | output | 1 | Buffer resynchronise strobe |

## Verification
The properties assume the line indications come from a single decoder. INFO 0 is therefore never raised in the same cycle as a signal-present, INFO 2, INFO 4 or loss-of-sync indication. The properties also treat the command code as a level that is read every cycle. The random stimulus picks at most one line event per cycle, and raises `rx_any_i` only alone or together with INFO 2 or INFO 4. Ticks, clock readiness, slip events and the threshold select vary independently. Directed sequences then walk every transition path and both timed waits, including restarts partway through a wait.

// File: rtl/l1t_pkg.sv
package l1t_pkg;

  typedef enum logic [2:0] {
    ST_PDN, ST_PUP, ST_PDEACT, ST_PACT, ST_UNSYN, ST_SYN, ST_ACT, ST_SLIP
  } l1_state_e;

  typedef struct packed {
    logic info0;
    logic any;
    logic info2;
    logic info4;
    logic lsync;
  } line_ind_t;

  localparam logic [3:0] CMD_TIM = 4'h0;
  localparam logic [3:0] CMD_AR  = 4'h8;
  localparam logic [3:0] CMD_DI  = 4'hF;

  localparam logic [1:0] TX_INFO0 = 2'b00;
  localparam logic [1:0] TX_INFO1 = 2'b01;
  localparam logic [1:0] TX_INFO3 = 2'b11;

  localparam logic [3:0] IND_DEACT = 4'hF;
  localparam logic [3:0] IND_PWRUP = 4'h7;
  localparam logic [3:0] IND_DREQ  = 4'h0;
  localparam logic [3:0] IND_RSYNC = 4'h4;
  localparam logic [3:0] IND_SYNC  = 4'h8;
  localparam logic [3:0] IND_ACT   = 4'hC;
  localparam logic [3:0] IND_SLIP  = 4'h2;

  function automatic logic [3:0] ind_code(l1_state_e s);
    case (s)
      ST_PDN:    return IND_DEACT;
      ST_PUP:    return IND_PWRUP;
      ST_PDEACT: return IND_DREQ;
      ST_PACT:   return IND_PWRUP;
      ST_UNSYN:  return IND_RSYNC;
      ST_SYN:    return IND_SYNC;
      ST_ACT:    return IND_ACT;
      default:   return IND_SLIP;
    endcase
  endfunction

  function automatic logic [1:0] tx_code(l1_state_e s);
    case (s)
      ST_PACT:                 return TX_INFO1;
      ST_SYN, ST_ACT, ST_SLIP: return TX_INFO3;
      default:                 return TX_INFO0;
    endcase
  endfunction

endpackage

// File: rtl/l1t_timer.sv
module l1t_timer #(
  parameter int TICKS = 8,
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             tick_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = en_i && tick_i && (cnt_q == CNT_W'(TICKS - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && tick_i && !done_o) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/l1t_fsm.sv
module l1t_fsm
  import l1t_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_ind_t line_i,
  input  logic [3:0] cmd_i,
  input  logic      slip_ev_i,
  input  logic      tmr_done_i,
  output l1_state_e state_q_o,
  output l1_state_e state_d_o
);
  l1_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PDN: begin
        if (line_i.any)              state_d = ST_UNSYN;
        else if (cmd_i == CMD_AR)    state_d = ST_PACT;
        else if (cmd_i == CMD_TIM)   state_d = ST_PUP;
      end
      ST_PUP: begin
        if (line_i.any)              state_d = ST_UNSYN;
        else if (cmd_i == CMD_DI)    state_d = ST_PDN;
        else if (cmd_i == CMD_AR)    state_d = ST_PACT;
      end
      ST_PDEACT, ST_PACT: begin
        if (line_i.any)              state_d = ST_UNSYN;
        else if (cmd_i == CMD_DI)    state_d = ST_PDN;
      end
      ST_UNSYN: begin
        if (line_i.info0)                     state_d = ST_PDEACT;
        else if (line_i.info2 || line_i.info4) state_d = ST_SYN;
      end
      ST_SYN: begin
        if (line_i.info0)            state_d = ST_PDEACT;
        else if (line_i.lsync)       state_d = ST_UNSYN;
        else if (tmr_done_i)         state_d = ST_ACT;
      end
      ST_ACT: begin
        if (line_i.info0)            state_d = ST_PDEACT;
        else if (line_i.lsync)       state_d = ST_UNSYN;
        else if (slip_ev_i)          state_d = ST_SLIP;
      end
      ST_SLIP: begin
        if (line_i.info0)            state_d = ST_PDEACT;
        else if (line_i.lsync)       state_d = ST_UNSYN;
        else if (tmr_done_i)         state_d = ST_ACT;
      end
      default: state_d = ST_PDN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PDN;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;
endmodule

// File: rtl/l1t_ind.sv
module l1t_ind
  import l1t_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  l1_state_e  state_i,
  input  logic       clk_rdy_i,
  output logic [3:0] ind_o,
  output logic       ind_vld_o
);
  l1_state_e  rep_q;
  logic [3:0] ind_q;
  logic       vld_q;
  logic       ready;

  // power-up report waits for running clocks
  assign ready = (state_i != ST_PUP) || clk_rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q <= ST_PDN;
      ind_q <= IND_DEACT;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (state_i != rep_q && ready) begin
        rep_q <= state_i;
        ind_q <= ind_code(state_i);
        vld_q <= 1'b1;
      end
    end
  end

  assign ind_o     = ind_q;
  assign ind_vld_o = vld_q;
endmodule

// File: rtl/l1t_act_ctrl.sv
module l1t_act_ctrl
  import l1t_pkg::*;
#(
  parameter int HALF_MS_TICKS = 8,
  localparam int CNT_W = (HALF_MS_TICKS > 1) ? $clog2(HALF_MS_TICKS) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_info0_i,
  input  logic       rx_any_i,
  input  logic       rx_info2_i,
  input  logic       rx_info4_i,
  input  logic       rx_lsync_i,
  input  logic [3:0] cmd_i,
  input  logic       clk_rdy_i,
  input  logic       slip50_i,
  input  logic       slip25_i,
  input  logic       cfg_slip25_i,
  input  logic       tick_i,
  output logic [1:0] tx_o,
  output logic [3:0] ind_o,
  output logic       ind_vld_o,
  output logic       resync_o
);
  line_ind_t        line;
  l1_state_e        state_q, state_d;
  logic             slip_ev, tmr_en, tmr_clr, tmr_done;
  logic [CNT_W-1:0] tmr_cnt;
  logic             seen4_q, resync_q;

  assign line = '{info0: rx_info0_i, any: rx_any_i, info2: rx_info2_i,
                  info4: rx_info4_i, lsync: rx_lsync_i};

  assign slip_ev = cfg_slip25_i ? slip25_i : slip50_i;
  assign tmr_clr = (state_d != state_q);
  assign tmr_en  = (state_q == ST_SLIP) ||
                   ((state_q == ST_SYN) && (seen4_q || rx_info4_i));

  l1t_fsm u_fsm (
    .clk_i, .rst_ni, .line_i(line), .cmd_i, .slip_ev_i(slip_ev),
    .tmr_done_i(tmr_done), .state_q_o(state_q), .state_d_o(state_d)
  );

  l1t_timer #(.TICKS(HALF_MS_TICKS)) u_tmr (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .en_i(tmr_en), .tick_i,
    .done_o(tmr_done), .cnt_o(tmr_cnt)
  );

  l1t_ind u_ind (
    .clk_i, .rst_ni, .state_i(state_q), .clk_rdy_i, .ind_o, .ind_vld_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen4_q  <= 1'b0;
      resync_q <= 1'b0;
    end else begin
      seen4_q  <= tmr_clr ? 1'b0 : (seen4_q || (state_q == ST_SYN && rx_info4_i));
      resync_q <= (state_d == ST_SLIP) && (state_q != ST_SLIP);
    end
  end

  assign tx_o     = tx_code(state_q);
  assign resync_o = resync_q;
endmodule

// File: rtl/l1t_act_chk.sv
module l1t_act_chk
  import l1t_pkg::*;
#(
  parameter int HALF_MS_TICKS = 8,
  localparam int CNT_W = (HALF_MS_TICKS > 1) ? $clog2(HALF_MS_TICKS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_info0_i,
  input logic             rx_any_i,
  input logic [3:0]       cmd_i,
  input logic [1:0]       tx_o,
  input logic [3:0]       ind_o,
  input logic             ind_vld_o,
  input logic             resync_o,
  input l1_state_e        state_q,
  input logic             tmr_done,
  input logic [CNT_W-1:0] tmr_cnt
);
  AST_DEACT_ON_INFO0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_info0_i && (state_q == ST_UNSYN || state_q == ST_SYN ||
                    state_q == ST_ACT || state_q == ST_SLIP))
    |=> state_q == ST_PDEACT); // R3

  AST_PDEACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PDEACT && !rx_any_i && cmd_i != CMD_DI)
    |=> state_q == ST_PDEACT); // R4

  AST_PACT_INFO1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PACT && !rx_any_i && cmd_i != CMD_DI)
    |=> tx_o == TX_INFO1); // R5

  AST_SYN_WAITS_TIMER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SYN && !tmr_done) |=> state_q != ST_ACT); // R8

  AST_RESYNC_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_SLIP) |-> resync_o); // R9

  AST_RESYNC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |=> !resync_o); // R9

  AST_TMR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(tmr_cnt) < HALF_MS_TICKS); // R10

  AST_IND_WITH_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ind_o) |-> ind_vld_o); // R11
endmodule

bind l1t_act_ctrl l1t_act_chk #(.HALF_MS_TICKS(HALF_MS_TICKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_info0_i(rx_info0_i), .rx_any_i(rx_any_i),
  .cmd_i(cmd_i), .tx_o(tx_o), .ind_o(ind_o), .ind_vld_o(ind_vld_o),
  .resync_o(resync_o), .state_q(state_q), .tmr_done(tmr_done), .tmr_cnt(tmr_cnt)
);

// File: tb/tb_l1t_act_ctrl.sv
`timescale 1ns/1ps
module tb_l1t_act_ctrl;
  localparam int N = 8;
  localparam int S_PDN = 0, S_PUP = 1, S_PDEACT = 2, S_PACT = 3,
                 S_UNSYN = 4, S_SYN = 5, S_ACT = 6, S_SLIP = 7;
  localparam logic [3:0] C_TIM = 4'h0, C_AR = 4'h8, C_DI = 4'hF, C_NOP = 4'h3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, i0, any, i2, i4, ls, rdy, s50, s25, cfg, tick;
  logic [3:0] cmd;
  logic [1:0] tx;
  logic [3:0] ind;
  logic ind_vld, rsy;

  l1t_act_ctrl #(.HALF_MS_TICKS(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_info0_i(i0), .rx_any_i(any),
    .rx_info2_i(i2), .rx_info4_i(i4), .rx_lsync_i(ls), .cmd_i(cmd),
    .clk_rdy_i(rdy), .slip50_i(s50), .slip25_i(s25), .cfg_slip25_i(cfg),
    .tick_i(tick), .tx_o(tx), .ind_o(ind), .ind_vld_o(ind_vld), .resync_o(rsy)
  );

  int checks = 0, errors = 0;
  bit done_run = 0;
  int m_st, m_cnt, m_rep;
  bit m_seen, m_vld, m_rsy;
  logic [3:0] m_ind;

  function automatic logic [3:0] code(int s);
    case (s)
      S_PDN: return 4'hF;  S_PUP: return 4'h7;  S_PDEACT: return 4'h0;
      S_PACT: return 4'h7; S_UNSYN: return 4'h4; S_SYN: return 4'h8;
      S_ACT: return 4'hC;  default: return 4'h2;
    endcase
  endfunction

  function automatic logic [1:0] txv(int s);
    if (s == S_PACT) return 2'b01;
    if (s == S_SYN || s == S_ACT || s == S_SLIP) return 2'b11;
    return 2'b00;
  endfunction

  function automatic int f_next(int s, bit slip, bit tdone);
    case (s)
      S_PDN:  return any ? S_UNSYN : (cmd == C_AR) ? S_PACT : (cmd == C_TIM) ? S_PUP : s;
      S_PUP:  return any ? S_UNSYN : (cmd == C_DI) ? S_PDN : (cmd == C_AR) ? S_PACT : s;
      S_PDEACT, S_PACT: return any ? S_UNSYN : (cmd == C_DI) ? S_PDN : s;
      S_UNSYN: return i0 ? S_PDEACT : (i2 || i4) ? S_SYN : s;
      S_SYN, S_SLIP: return i0 ? S_PDEACT : ls ? S_UNSYN : tdone ? S_ACT : s;
      default: return i0 ? S_PDEACT : ls ? S_UNSYN : slip ? S_SLIP : s;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = S_PDN; m_cnt = 0; m_rep = S_PDN; m_seen = 0;
    m_ind = 4'hF; m_vld = 0; m_rsy = 0;
  endtask

  task automatic idle();
    i0 = 0; any = 0; i2 = 0; i4 = 0; ls = 0; cmd = C_NOP; s50 = 0; s25 = 0; tick = 0;
  endtask

  task automatic step(string tag);
    bit slip, en, tdone, chg, ready;
    int nxt;
    slip  = cfg ? s25 : s50;
    en    = (m_st == S_SLIP) || (m_st == S_SYN && (m_seen || i4));
    tdone = en && tick && (m_cnt == N - 1);
    nxt   = f_next(m_st, slip, tdone);
    ready = (m_st != S_PUP) || rdy;
    chg   = (nxt != m_st);
    @(posedge clk);
    @(negedge clk);
    m_vld = 0;
    if (m_st != m_rep && ready) begin
      m_rep = m_st; m_ind = code(m_st); m_vld = 1;
    end
    m_rsy  = (nxt == S_SLIP) && (m_st != S_SLIP);
    m_seen = chg ? 0 : (m_seen || (m_st == S_SYN && i4));
    m_cnt  = chg ? 0 : (en && tick) ? m_cnt + 1 : m_cnt;
    m_st   = nxt;
    chk(tag, "tx_o", 8'(tx), 8'(txv(m_st)));
    chk(tag, "ind_o", 8'(ind), 8'(m_ind));
    chk(tag, "ind_vld_o", 8'(ind_vld), 8'(m_vld));
    chk(tag, "resync_o", 8'(rsy), 8'(m_rsy));
  endtask

  task automatic steps(string tag, int n);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  initial begin
    #(4 * 190000);
    if (!done_run) begin
      checks++; errors++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(); rdy = 0; cfg = 0; rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "tx_o", 8'(tx), 8'h00);
    chk("R1", "ind_o", 8'(ind), 8'h0F);
    chk("R1", "ind_vld_o", 8'(ind_vld), 8'h0);
    chk("R1", "resync_o", 8'(rsy), 8'h0);
    rst_n = 1;
    steps("R1", 2);

    // R2 power up, report waits for clocks
    cmd = C_TIM; step("R2");
    cmd = C_NOP; steps("R2", 3);
    rdy = 1; steps("R2", 2);
    // R12 unknown commands
    cmd = 4'h5; steps("R12", 3);
    cmd = 4'hA; steps("R12", 2);
    // R5 activation request, no timeout
    cmd = C_AR; step("R5");
    cmd = C_NOP; tick = 1; steps("R5", 3 * N);
    cmd = C_TIM; steps("R5", 2);
    cmd = C_NOP; tick = 0;
    // R6 line signal ends INFO 1
    any = 1; step("R6");
    any = 0; steps("R6", 2);
    // R7 INFO 2 to synchronized; no INFO 4 yet so no count
    i2 = 1; any = 1; step("R7");
    i2 = 0; tick = 1; steps("R7", 2 * N);
    // R8 count from first INFO 4, tick every other cycle
    i4 = 1;
    for (int k = 0; k < 3 * N; k++) begin tick = k[0]; step("R8"); end
    tick = 0; i4 = 0; any = 0;
    // R9 slip with wide threshold; narrow input ignored
    s25 = 1; steps("R9", 2); s25 = 0;
    s50 = 1; step("R9"); s50 = 0;
    tick = 1; steps("R9", N + 2);
    cfg = 1; s50 = 1; steps("R9", 2); s50 = 0;
    s25 = 1; step("R9"); s25 = 0;
    steps("R9", 3);
    // R10 slip interrupted by loss of sync, then full wait again in synchronized
    ls = 1; step("R10"); ls = 0;
    i4 = 1; any = 1; steps("R10", N / 2);
    ls = 1; step("R10"); ls = 0;
    steps("R10", N + 3);
    i4 = 0; any = 0;
    // R3 INFO 0 from activated
    i0 = 1; step("R3"); i0 = 0;
    // R4 pending deactivation ignores AR/TIM
    cmd = C_AR; steps("R4", 2);
    cmd = C_TIM; steps("R4", 2);
    cmd = C_NOP; any = 1; step("R4"); any = 0;
    i0 = 1; step("R3"); i0 = 0;
    cmd = C_DI; step("R4"); cmd = C_NOP;
    steps("R11", 2);

    // random phase
    for (int k = 0; k < 6000; k++) begin
      int r;
      idle();
      r = int'($urandom % 32);
      if (r < 2) i0 = 1;
      else if (r < 4) ls = 1;
      else if (r < 7) begin i2 = 1; any = 1; end
      else if (r < 11) begin i4 = 1; any = 1; end
      else if (r < 12) any = 1;
      r = int'($urandom % 8);
      cmd = (r == 0) ? C_TIM : (r == 1) ? C_AR : (r == 2) ? C_DI : 4'($urandom);
      tick = ($urandom % 3 == 0);
      rdy  = ($urandom % 4 != 0);
      s50  = ($urandom % 12 == 0);
      s25  = ($urandom % 12 == 0);
      if ($urandom % 64 == 0) cfg = ~cfg;
      step("R11");
    end

    done_run = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule